// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Flag Unit

This block is the interrupt side of a real-time clock. It keeps an alarm value for the seconds, minutes and hours. It also keeps a control byte that holds one enable for each of its three interrupt sources, and a flag byte that records events. The time-keeping logic feeds it the current seconds, minutes and hours together with a one-cycle strobe that marks the end of each time update. A separate divider supplies a one-cycle periodic tick.

At every update strobe the unit compares each alarm byte with its time field. A byte whose two top bits are both 1 matches any time value. When all three fields match, the alarm flag is raised. The update strobe itself raises the update-ended flag, and the periodic tick raises the periodic flag. A flag records its event whatever its enable is. The summary bit and the interrupt line are high only while some raised flag has its enable set.

A host reads and writes the unit through a simple register port. Reading the flag byte returns the flags and clears them at the same clock edge. An event that arrives in the cycle of that read is kept.

Top module: `rtc_alm_unit`

## Requirements
- R1: After reset the flag byte, the interrupt line, the three alarm bytes and the control byte are all 0.
- R2: Host writes to index 1 (seconds alarm), 3 (minutes alarm) and 5 (hours alarm) store the full byte, and reads of those indices return it. A write to index 11 stores bits 6 (periodic enable), 5 (alarm enable) and 4 (update enable), and a read of index 11 returns those bits with all other bits 0.
- R3: When the update strobe is high, the alarm flag (flag byte bit 5) is 1 in the next cycle if every alarm byte either equals its time field or has its bits 7 and 6 both set.
- R4: The alarm flag does not set if any alarm byte that lacks both top bits differs from its time field. A byte with only one of the two top bits set is not a wildcard. The alarm flag also does not set while the update strobe is low.
- R5: The update-ended flag (bit 4) is 1 in the cycle after an update strobe. The periodic flag (bit 6) is 1 in the cycle after a periodic tick.
- R6: Flags 6 to 4 set on their events even when the matching enable is 0.
- R7: Flag byte bit 7 equals the OR of each of flags 6 to 4 ANDed with its enable. The interrupt output always equals bit 7.
- R8: A host read of index 12 returns the current flag byte, and bits 7 to 4 are 0 in the next cycle unless a new event arrives. Bits 3 to 0 of the flag byte are always 0.
- R9: An event in the same cycle as a read of index 12 leaves its flag set in the next cycle.
- R10: Flags hold their value until index 12 is read. Reads of other indices and writes to any index, index 12 included, do not clear them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tm_sec | input | 8 | Current seconds value |
| tm_min | input | 8 | Current minutes value |
| tm_hour | input | 8 | Current hours value |
| upd_done | input | 1 | One-cycle strobe marking the end of a time update |
| per_tick | input | 1 | One-cycle periodic event |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable (a read of index 12 clears the flags) |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| flag_reg | output | 8 | Flag byte: bit 7 summary, bits 6 to 4 periodic, alarm and update flags |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions check on every cycle that an update strobe or a periodic tick raises its flag, and that a flag-byte read with no coincident event clears the flags. They also check that an event coinciding with such a read survives, that flags otherwise stay unchanged, and that the summary bit and interrupt line follow the flags and enables while the low nibble stays zero. Only the bench scenarios can show the alarm comparison itself: exact matches, wildcard bytes, bytes with a single top bit set, and a mismatch in one field. The same holds for register readback, the masking of unused control bits, and the value the host sees when a read and an event share a cycle.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    // register indices seen by the host
    localparam int IDX_CTRL = 11;
    localparam int IDX_FLAG = 12;

    // bit positions shared by the control byte and the flag byte
    localparam int BIT_SUM = 7;
    localparam int BIT_PER = 6;
    localparam int BIT_ALM = 5;
    localparam int BIT_UPD = 4;

    // one bit per interrupt source, in flag-byte order
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_t;

    // index of alarm field i (seconds, minutes, hours)
    function automatic int alarm_index(input int i);
        return 2 * i + 1;
    endfunction

endpackage

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
#(
    parameter int DW = 8,
    parameter int NF = 3
)
(
    input  logic [NF*DW-1:0] alarm_flat,
    input  logic [NF*DW-1:0] time_flat,
    output logic             all_match
);

    logic [NF-1:0] field_ok;

    generate
        for (genvar gi = 0; gi < NF; gi++) begin : g_field
            logic [DW-1:0] alm_b;
            logic [DW-1:0] tim_b;
            logic          wild;
            assign alm_b = alarm_flat[gi*DW +: DW];
            assign tim_b = time_flat[gi*DW +: DW];
            // both top bits set: the byte is a don't-care
            assign wild  = &alm_b[DW-1:DW-2];
            assign field_ok[gi] = wild || (alm_b == tim_b);
        end
    endgenerate

    assign all_match = &field_ok;

endmodule

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
    import rtc_alm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int NF = 3
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [NF*DW-1:0] alarm_flat,
    output src_t             en,
    output logic [DW-1:0]    rdata
);

    typedef struct packed {
        logic [NF-1:0][DW-1:0] alm;
        src_t                  en;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            for (int i = 0; i < NF; i++) begin
                if (addr == AW'(alarm_index(i))) begin
                    st_d.alm[i] = wdata;
                end
            end
            if (addr == AW'(IDX_CTRL)) begin
                st_d.en.per = wdata[BIT_PER];
                st_d.en.alm = wdata[BIT_ALM];
                st_d.en.upd = wdata[BIT_UPD];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (addr == AW'(alarm_index(i))) begin
                rdata = st_q.alm[i];
            end
        end
        if (addr == AW'(IDX_CTRL)) begin
            rdata[BIT_PER] = st_q.en.per;
            rdata[BIT_ALM] = st_q.en.alm;
            rdata[BIT_UPD] = st_q.en.upd;
        end
    end

    assign alarm_flat = st_q.alm;
    assign en         = st_q.en;

endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_t set,
    input  logic clr,
    output src_t flags
);

    src_t fl_d, fl_q;

    always_comb begin
        // clear first, then let events of this cycle win
        fl_d = clr ? '0 : fl_q;
        fl_d = fl_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/rtc_alm_unit.sv
module rtc_alm_unit
    import rtc_alm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tm_sec,
    input  logic [DW-1:0] tm_min,
    input  logic [DW-1:0] tm_hour,
    input  logic          upd_done,
    input  logic          per_tick,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] flag_reg,
    output logic          irq
);

    localparam int NF = 3;

    logic [NF*DW-1:0] alarm_flat;
    logic [NF*DW-1:0] time_flat;
    logic             alarm_hit;
    logic [DW-1:0]    cfg_rdata;
    logic             flag_read;
    src_t             src_en;
    src_t             src_set;
    src_t             src_flags;
    logic             summary;

    assign time_flat = {tm_hour, tm_min, tm_sec};
    assign flag_read = host_rd && (host_addr == AW'(IDX_FLAG));

    rtc_alm_regs #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (host_wr),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .alarm_flat (alarm_flat),
        .en         (src_en),
        .rdata      (cfg_rdata)
    );

    rtc_alm_cmp #(.DW(DW), .NF(NF)) u_cmp (
        .alarm_flat (alarm_flat),
        .time_flat  (time_flat),
        .all_match  (alarm_hit)
    );

    always_comb begin
        src_set.per = per_tick;
        src_set.upd = upd_done;
        src_set.alm = upd_done && alarm_hit;
    end

    rtc_alm_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (src_set),
        .clr   (flag_read),
        .flags (src_flags)
    );

    assign summary = |(src_flags & src_en);

    always_comb begin
        flag_reg          = '0;
        flag_reg[BIT_SUM] = summary;
        flag_reg[BIT_PER] = src_flags.per;
        flag_reg[BIT_ALM] = src_flags.alm;
        flag_reg[BIT_UPD] = src_flags.upd;
    end

    assign irq = summary;

    always_comb begin
        if (host_addr == AW'(IDX_FLAG)) begin
            host_rdata = flag_reg;
        end else begin
            host_rdata = cfg_rdata;
        end
    end

endmodule

// File: rtl/rtc_alm_chk.sv
module rtc_alm_chk
    import rtc_alm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
)
(
    input logic          clk,
    input logic          rst_n,
    input logic          upd_done,
    input logic          per_tick,
    input logic          host_rd,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] flag_reg,
    input logic          irq,
    input logic [2:0]    en
);

    logic rd_flag;
    logic quiet;
    assign rd_flag = host_rd && (host_addr == AW'(IDX_FLAG));
    assign quiet   = !upd_done && !per_tick;

    a_r5_upd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flag_reg[BIT_UPD]);

    a_r5_per_sets: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> flag_reg[BIT_PER]);

    a_r7_irq_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == flag_reg[BIT_SUM]) &&
        (flag_reg[BIT_SUM] == |(flag_reg[BIT_PER:BIT_UPD] & en)));

    a_r8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_reg[BIT_UPD-1:0] == '0);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && quiet) |=> (flag_reg[BIT_PER:BIT_UPD] == '0));

    a_r9_keep_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && upd_done) |=> flag_reg[BIT_UPD]);

    a_r9_keep_per: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && per_tick) |=> flag_reg[BIT_PER]);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_flag && quiet) |=>
        (flag_reg[BIT_PER:BIT_UPD] == $past(flag_reg[BIT_PER:BIT_UPD])));

endmodule

bind rtc_alm_unit rtc_alm_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_done  (upd_done),
    .per_tick  (per_tick),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .flag_reg  (flag_reg),
    .irq       (irq),
    .en        (src_en)
);

// File: tb/rtc_alm_unit_bench.sv
module rtc_alm_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
    logic       upd_done = 1'b0, per_tick = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, flag_reg;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_alm [3];
    logic [2:0] m_en;
    logic [2:0] m_fl;

    always #2.5 clk = ~clk;

    rtc_alm_unit u_rtc_alm_unit (
        .clk(clk), .rst_n(rst_n), .tm_sec(tm_sec), .tm_min(tm_min),
        .tm_hour(tm_hour), .upd_done(upd_done), .per_tick(per_tick),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .flag_reg(flag_reg), .irq(irq)
    );

    function automatic logic fmatch(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    function automatic logic [7:0] exp_flag();
        return {|(m_fl & m_en), m_fl, 4'b0000};
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd1:    return m_alm[0];
            4'd3:    return m_alm[1];
            4'd5:    return m_alm[2];
            4'd11:   return {1'b0, m_en, 4'b0000};
            4'd12:   return exp_flag();
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus; inputs change 1 ns after the rising edge
    task automatic step(input string tag, input logic wr, input logic rd,
                        input logic [3:0] a, input logic [7:0] wd,
                        input logic upd, input logic per,
                        input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        logic hit;
        logic [2:0] nfl;
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        upd_done = upd; per_tick = per;
        tm_sec = s; tm_min = m; tm_hour = h;
        #1;
        if (rd) check(tag, host_rdata, exp_read(a));
        hit = upd && fmatch(m_alm[0], s) && fmatch(m_alm[1], m) && fmatch(m_alm[2], h);
        nfl = (rd && a == 4'd12) ? 3'b000 : m_fl;
        nfl = nfl | {per, hit, upd};
        @(posedge clk);
        #1;
        m_fl = nfl;
        if (wr) begin
            if (a == 4'd1) m_alm[0] = wd;
            if (a == 4'd3) m_alm[1] = wd;
            if (a == 4'd5) m_alm[2] = wd;
            if (a == 4'd11) m_en = wd[6:4];
        end
        host_wr = 1'b0; host_rd = 1'b0; upd_done = 1'b0; per_tick = 1'b0;
        check(tag, flag_reg, exp_flag());
        check(tag, {7'b0, irq}, {7'b0, exp_flag()[7]});
    endtask

    task automatic wr_reg(input string tag, input logic [3:0] a, input logic [7:0] d);
        step(tag, 1'b1, 1'b0, a, d, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] a);
        step(tag, 1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic update(input string tag, input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        step(tag, 1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0, s, m, h);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < 3; i++) m_alm[i] = 8'h00;
        m_en = 3'b000;
        m_fl = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", flag_reg, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        rd_reg("R1", 4'd1);
        rd_reg("R1", 4'd3);
        rd_reg("R1", 4'd5);
        rd_reg("R1", 4'd11);

        // R2: readback, unused control bits masked
        wr_reg("R2", 4'd1, 8'h12);
        wr_reg("R2", 4'd3, 8'h34);
        wr_reg("R2", 4'd5, 8'h56);
        wr_reg("R2", 4'd11, 8'h8F);
        rd_reg("R2", 4'd1);
        rd_reg("R2", 4'd3);
        rd_reg("R2", 4'd5);
        rd_reg("R2", 4'd11);
        check("R2", host_rdata, 8'h00);
        wr_reg("R2", 4'd11, 8'h00);

        // R3 + R6: exact match with all enables off
        update("R3", 8'h12, 8'h34, 8'h56);
        check("R6", flag_reg, 8'h30);
        // R8: read returns flags, then clears
        rd_reg("R8", 4'd12);
        check("R8", flag_reg, 8'h00);

        // R4: one field differs
        update("R4", 8'h12, 8'h35, 8'h56);
        check("R4", flag_reg, 8'h10);
        rd_reg("R8", 4'd12);
        // R4: no strobe, times match, no alarm
        step("R4", 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 8'h12, 8'h34, 8'h56);
        check("R4", flag_reg, 8'h00);

        // R3: wildcard minutes
        wr_reg("R3", 4'd3, 8'hC5);
        update("R3", 8'h12, 8'h07, 8'h56);
        check("R3", flag_reg, 8'h30);
        rd_reg("R8", 4'd12);
        // R4: only bit 7 set is not a wildcard
        wr_reg("R4", 4'd1, 8'h80);
        update("R4", 8'h00, 8'h07, 8'h56);
        check("R4", flag_reg, 8'h10);
        rd_reg("R8", 4'd12);

        // R5 + R7
        step("R5", 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R5", flag_reg, 8'h40);
        wr_reg("R7", 4'd11, 8'h40);
        check("R7", flag_reg, 8'hC0);
        wr_reg("R7", 4'd11, 8'h20);
        check("R7", flag_reg, 8'h40);

        // R10: other accesses do not clear
        wr_reg("R10", 4'd12, 8'h00);
        wr_reg("R10", 4'd13, 8'hFF);
        rd_reg("R10", 4'd11);
        rd_reg("R10", 4'd13);
        check("R10", flag_reg, 8'h40);

        // R9: event coinciding with a read of the flag byte
        step("R9", 1'b0, 1'b1, 4'd12, 8'h00, 1'b1, 1'b0, 8'h01, 8'h02, 8'h03);
        check("R9", flag_reg, 8'h10);
        step("R9", 1'b0, 1'b1, 4'd12, 8'h00, 1'b0, 1'b1, 8'h01, 8'h02, 8'h03);
        check("R9", flag_reg, 8'h40);

        // random phase
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [3:0] a;
            logic [7:0] d, s, m, h;
            kind = $urandom_range(0, 5);
            case ($urandom_range(0, 6))
                0: a = 4'd1;  1: a = 4'd3;  2: a = 4'd5;
                3: a = 4'd11; 4: a = 4'd12; 5: a = 4'd0;
                default: a = 4'd12;
            endcase
            d = ($urandom_range(0, 3) == 0) ? (8'hC0 | 8'($urandom_range(0, 63)))
                                            : 8'($urandom_range(0, 7));
            s = ($urandom_range(0, 1) != 0) ? m_alm[0] : 8'($urandom_range(0, 7));
            m = ($urandom_range(0, 1) != 0) ? m_alm[1] : 8'($urandom_range(0, 7));
            h = ($urandom_range(0, 1) != 0) ? m_alm[2] : 8'($urandom_range(0, 7));
            if (a == 4'd11) d = 8'($urandom);
            case (kind)
                0: step("R2", 1'b1, 1'b0, a, d, 1'b0, 1'b0, s, m, h);
                1: step("R8", 1'b0, 1'b1, a, 8'h00,
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), s, m, h);
                2: step("R3", 1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0, s, m, h);
                3: step("R5", 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, s, m, h);
                default: step("R7", 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, s, m, h);
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule